// File: doc/BRIEF.md
# ATA Drive Timing Word Generator

This block turns the negotiated transfer modes of the two drives on one ATA channel into 32-bit access-timing words. A single timing register sits in front of the drives. On each start pulse the block snapshots, for each drive, a present flag, a multiword-DMA enable, an Ultra-DMA enable and the three mode numbers. It looks up the minimum cycle and active times in nanoseconds for each mode and converts them to clock ticks by rounding up. It then packs the ticks into one of two field layouts. `fmt_fast` picks the layout: the older 30 ns tick format or the newer 15 ns tick format.

After both words are built, the block writes the first nonzero word to the timing register. It then decides whether the register has to be rewritten when the host switches drives. That happens only when both words are nonzero and they differ. While rewriting is armed, every select pulse loads the chosen drive's word onto `cfg_word` with a one-cycle `cfg_we` strobe.

The controller has three states and uses the following transitions:
- IDLE waits for `start`. On `start` it goes to CALC ("launch").
- CALC spends one cycle per drive, drive 0 first. After drive 0 it stays in CALC ("next drive"). After drive 1 it goes to COMMIT ("last drive").
- COMMIT issues the initial write and the done pulse, then returns to IDLE ("finish").
- Select pulses are served only in IDLE.

Top module: `ata_timing_cfg`

## Requirements
- R1: In the 30 ns format, ticks are ceil(ns/30). PIO packing works as follows:
  - The active count is clamped to at least 1.
  - Recovery = cycle − active − 4, clamped to at least 1.
  - The word holds active in bits [4:0] and recovery in bits [10:5].
  - Table (cycle/active ns), PIO 0..4: 600/180, 390/150, 240/105, 180/90, 120/75.
- R2: In the 30 ns format, multiword DMA packing works as follows:
  - Active goes in bits [15:11].
  - Recovery = cycle − active − 1, clamped to at least 1, goes in bits [20:16].
  - Bit 21 is always 0.
  - Table, DMA 0..2: 480/240, 165/90, 120/75.
- R3: In the 15 ns format, ticks are ceil(ns/15). PIO packing puts active in bits [4:0] and recovery = cycle − active (no offset, no clamp) in bits [9:5].
- R4: In the 15 ns format, multiword DMA packing puts active in bits [14:10] and recovery = cycle − active in bits [19:15].
- R5: In the 15 ns format, UDMA packing sets bit 20, puts cycle ticks in bits [24:21] and active ticks in bits [28:25]. Table, UDMA 0..4: 120/180, 90/150, 60/120, 45/90, 30/90. In the 30 ns format the UDMA enable is ignored.
- R6: Each field group is included only when its flag is set: present for PIO, DMA enable for DMA, UDMA enable for UDMA. A drive with no flags set yields 0.
- R7: An enabled group whose mode is out of range (PIO > 4, DMA > 2, UDMA > 4) forces that drive's word to 0 and sets `mode_err`. A mode with its flag clear raises no error. `mode_err` clears on the next start.
- R8: `done` pulses for one cycle, 4 cycles after the start cycle. In that same cycle the block writes the initial value:
  - If drive 0's word is nonzero, `cfg_we` pulses with that word.
  - Otherwise, if drive 1's word is nonzero, `cfg_we` pulses with drive 1's word.
  - Otherwise no strobe is issued.
- R9: `rewrite_armed` is set after a computation exactly when both words are nonzero and different.
- R10: While armed and idle, a `sel_valid` pulse gives, one cycle later, a one-cycle `cfg_we` with the word of `sel_drive` (0 or 1). While not armed, select pulses produce no strobe.
- R11: `busy` is high from the cycle after an accepted start until `done`. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a computation from the current mode inputs |
| fmt_fast | input | 1 | 1 = 15 ns tick layout, 0 = 30 ns tick layout |
| drv_present | input | 2 | Per-drive present flag (bit i = drive i) |
| drv_dma_en | input | 2 | Per-drive multiword-DMA enable |
| drv_udma_en | input | 2 | Per-drive Ultra-DMA enable |
| pio_mode | input | 6 | PIO mode, 3 bits per drive, drive 0 in bits [2:0] |
| dma_mode | input | 6 | Multiword DMA mode, 3 bits per drive |
| udma_mode | input | 6 | Ultra-DMA mode, 3 bits per drive |
| sel_valid | input | 1 | Drive-select pulse |
| sel_drive | input | 1 | Index of the selected drive |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| mode_err | output | 1 | An enabled mode was out of range |
| rewrite_armed | output | 1 | Per-select rewriting is enabled |
| cfg_we | output | 1 | Timing-register write strobe |
| cfg_word | output | 32 | Timing-register value |

## Verification
A wrong tick conversion or a misplaced field shows up as a wrong `cfg_word` on the commit strobe, four cycles after start. A corrupted stored word for the second drive stays hidden until a later select pulse, one cycle after that select. A wrong arming decision shows either as a missing strobe after a select or as a stray strobe when only one drive is configured. The directed tests therefore pair each computation with select pulses to both drives. A controller stuck out of IDLE shows as `done` never arriving and `busy` staying high.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;
    localparam int MODE_W  = 3;
    localparam int NS_W    = 11;
    localparam int TICK_W  = 6;
    localparam int WORD_W  = 32;
    localparam int N_DRV   = 2;
    localparam int N_CLS   = 3;

    typedef enum logic [1:0] {
        XF_PIO  = 2'd0,
        XF_MDMA = 2'd1,
        XF_UDMA = 2'd2
    } xfer_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_COMMIT = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic              present;
        logic              dma_en;
        logic              udma_en;
        logic [MODE_W-1:0] pio;
        logic [MODE_W-1:0] dma;
        logic [MODE_W-1:0] udma;
    } drv_cfg_t;
endpackage

// File: rtl/ata_mode_lut.sv
module ata_mode_lut
    import ata_tim_pkg::*;
#(
    parameter xfer_cls_e CLS = XF_PIO
) (
    input  logic [MODE_W-1:0] mode,
    output logic [NS_W-1:0]   cyc_ns,
    output logic [NS_W-1:0]   act_ns,
    output logic              in_range
);
    always_comb begin
        cyc_ns   = '0;
        act_ns   = '0;
        in_range = 1'b1;
        unique case (CLS)
            XF_PIO: begin
                unique case (mode)
                    3'd0:    begin cyc_ns = 11'd600; act_ns = 11'd180; end
                    3'd1:    begin cyc_ns = 11'd390; act_ns = 11'd150; end
                    3'd2:    begin cyc_ns = 11'd240; act_ns = 11'd105; end
                    3'd3:    begin cyc_ns = 11'd180; act_ns = 11'd90;  end
                    3'd4:    begin cyc_ns = 11'd120; act_ns = 11'd75;  end
                    default: in_range = 1'b0;
                endcase
            end
            XF_MDMA: begin
                unique case (mode)
                    3'd0:    begin cyc_ns = 11'd480; act_ns = 11'd240; end
                    3'd1:    begin cyc_ns = 11'd165; act_ns = 11'd90;  end
                    3'd2:    begin cyc_ns = 11'd120; act_ns = 11'd75;  end
                    default: in_range = 1'b0;
                endcase
            end
            default: begin
                unique case (mode)
                    3'd0:    begin cyc_ns = 11'd120; act_ns = 11'd180; end
                    3'd1:    begin cyc_ns = 11'd90;  act_ns = 11'd150; end
                    3'd2:    begin cyc_ns = 11'd60;  act_ns = 11'd120; end
                    3'd3:    begin cyc_ns = 11'd45;  act_ns = 11'd90;  end
                    3'd4:    begin cyc_ns = 11'd30;  act_ns = 11'd90;  end
                    default: in_range = 1'b0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/ata_tick_conv.sv
module ata_tick_conv
    import ata_tim_pkg::*;
#(
    parameter int SLOW_NS = 30
) (
    input  logic [NS_W-1:0]   ns,
    input  logic              fast,
    output logic [TICK_W-1:0] ticks
);
    localparam int FAST_NS = SLOW_NS / 2;

    always_comb begin
        if (fast)
            ticks = TICK_W'((32'(ns) + FAST_NS - 1) / FAST_NS);
        else
            ticks = TICK_W'((32'(ns) + SLOW_NS - 1) / SLOW_NS);
    end
endmodule

// File: rtl/ata_word_pack.sv
module ata_word_pack
    import ata_tim_pkg::*;
#(
    parameter int SLOW_NS = 30
) (
    input  drv_cfg_t          cfg,
    input  logic              fast,
    output logic [WORD_W-1:0] word,
    output logic              err
);
    localparam int LEG_PIO_OFS = 4;
    localparam int LEG_DMA_OFS = 1;

    logic [NS_W-1:0]   cyc_ns [N_CLS];
    logic [NS_W-1:0]   act_ns [N_CLS];
    logic              ok     [N_CLS];
    logic [TICK_W-1:0] cyc_t  [N_CLS];
    logic [TICK_W-1:0] act_t  [N_CLS];
    logic [MODE_W-1:0] mode_v [N_CLS];

    assign mode_v[0] = cfg.pio;
    assign mode_v[1] = cfg.dma;
    assign mode_v[2] = cfg.udma;

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        ata_mode_lut #(.CLS(xfer_cls_e'(c))) u_lut (
            .mode     (mode_v[c]),
            .cyc_ns   (cyc_ns[c]),
            .act_ns   (act_ns[c]),
            .in_range (ok[c])
        );
        ata_tick_conv #(.SLOW_NS(SLOW_NS)) u_cyc (
            .ns    (cyc_ns[c]),
            .fast  (fast),
            .ticks (cyc_t[c])
        );
        ata_tick_conv #(.SLOW_NS(SLOW_NS)) u_act (
            .ns    (act_ns[c]),
            .fast  (fast),
            .ticks (act_t[c])
        );
    end

    logic [WORD_W-1:0] acc;
    logic [TICK_W-1:0] pio_act;
    logic signed [TICK_W+1:0] pio_rec;
    logic signed [TICK_W+1:0] dma_rec;
    logic udma_use;

    always_comb begin
        acc      = '0;
        udma_use = fast && cfg.udma_en;
        pio_act  = act_t[0];
        pio_rec  = $signed({2'b00, cyc_t[0]}) - $signed({2'b00, act_t[0]});
        dma_rec  = $signed({2'b00, cyc_t[1]}) - $signed({2'b00, act_t[1]});
        if (!fast) begin
            if (pio_act == '0) pio_act = TICK_W'(1);
            pio_rec = $signed({2'b00, cyc_t[0]}) - $signed({2'b00, pio_act})
                      - (TICK_W+2)'(LEG_PIO_OFS);
            if (pio_rec < 1) pio_rec = (TICK_W+2)'(1);
            dma_rec = dma_rec - (TICK_W+2)'(LEG_DMA_OFS);
            if (dma_rec < 1) dma_rec = (TICK_W+2)'(1);
        end

        if (cfg.present) begin
            if (fast) begin
                acc[4:0] = pio_act[4:0];
                acc[9:5] = pio_rec[4:0];
            end else begin
                acc[4:0]  = pio_act[4:0];
                acc[10:5] = pio_rec[5:0];
            end
        end
        if (cfg.dma_en) begin
            if (fast) begin
                acc[14:10] = act_t[1][4:0];
                acc[19:15] = dma_rec[4:0];
            end else begin
                acc[15:11] = act_t[1][4:0];
                acc[20:16] = dma_rec[4:0];
                acc[21]    = 1'b0;
            end
        end
        if (udma_use) begin
            acc[20]    = 1'b1;
            acc[24:21] = cyc_t[2][3:0];
            acc[28:25] = act_t[2][3:0];
        end

        err  = (cfg.present && !ok[0]) || (cfg.dma_en && !ok[1]) ||
               (udma_use && !ok[2]);
        word = err ? '0 : acc;
    end
endmodule

// File: rtl/ata_timing_cfg.sv
module ata_timing_cfg
    import ata_tim_pkg::*;
#(
    parameter int SLOW_NS = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        fmt_fast,
    input  logic [1:0]  drv_present,
    input  logic [1:0]  drv_dma_en,
    input  logic [1:0]  drv_udma_en,
    input  logic [5:0]  pio_mode,
    input  logic [5:0]  dma_mode,
    input  logic [5:0]  udma_mode,
    input  logic        sel_valid,
    input  logic        sel_drive,
    output logic        busy,
    output logic        done,
    output logic        mode_err,
    output logic        rewrite_armed,
    output logic        cfg_we,
    output logic [31:0] cfg_word
);
    localparam int IDX_W = $clog2(N_DRV);

    ctl_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              fast_q;
    drv_cfg_t          snap_q [N_DRV];
    logic [WORD_W-1:0] words_q [N_DRV];
    logic [WORD_W-1:0] cur_word;
    logic              cur_err;
    logic              last_drv;

    assign last_drv = (idx_q == IDX_W'(N_DRV - 1));

    ata_word_pack #(.SLOW_NS(SLOW_NS)) u_pack (
        .cfg  (snap_q[idx_q]),
        .fast (fast_q),
        .word (cur_word),
        .err  (cur_err)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CALC;
            ST_CALC:   if (last_drv) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register, drive index, snapshot and stored words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            fast_q  <= 1'b0;
            for (int i = 0; i < N_DRV; i++) begin
                snap_q[i]  <= '0;
                words_q[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (start) begin
                        fast_q <= fmt_fast;
                        for (int i = 0; i < N_DRV; i++) begin
                            snap_q[i].present <= drv_present[i];
                            snap_q[i].dma_en  <= drv_dma_en[i];
                            snap_q[i].udma_en <= drv_udma_en[i];
                            snap_q[i].pio     <= pio_mode[i*MODE_W +: MODE_W];
                            snap_q[i].dma     <= dma_mode[i*MODE_W +: MODE_W];
                            snap_q[i].udma    <= udma_mode[i*MODE_W +: MODE_W];
                        end
                    end
                end
                ST_CALC: begin
                    words_q[idx_q] <= cur_word;
                    if (!last_drv) idx_q <= idx_q + 1'b1;
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            mode_err      <= 1'b0;
            rewrite_armed <= 1'b0;
            cfg_we        <= 1'b0;
            cfg_word      <= '0;
        end else begin
            done   <= 1'b0;
            cfg_we <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_err <= 1'b0;
                    end else if (sel_valid && rewrite_armed) begin
                        cfg_we   <= 1'b1;
                        cfg_word <= words_q[sel_drive];
                    end
                end
                ST_CALC: begin
                    if (cur_err) mode_err <= 1'b1;
                end
                ST_COMMIT: begin
                    done <= 1'b1;
                    if (words_q[0] != '0) begin
                        cfg_we        <= 1'b1;
                        cfg_word      <= words_q[0];
                        rewrite_armed <= (words_q[1] != '0) &&
                                         (words_q[1] != words_q[0]);
                    end else if (words_q[1] != '0) begin
                        cfg_we        <= 1'b1;
                        cfg_word      <= words_q[1];
                        rewrite_armed <= 1'b0;
                    end else begin
                        rewrite_armed <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/ata_timing_cfg_chk.sv
module ata_timing_cfg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        sel_valid,
    input logic        busy,
    input logic        done,
    input logic        rewrite_armed,
    input logic        cfg_we,
    input logic [31:0] cfg_word
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_no_sel_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !rewrite_armed && !busy && !start) |=> !cfg_we);

    p_nonzero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (cfg_word != 32'd0));

    p_no_we_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> !cfg_we || $past(busy));
endmodule

bind ata_timing_cfg ata_timing_cfg_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .sel_valid     (sel_valid),
    .busy          (busy),
    .done          (done),
    .rewrite_armed (rewrite_armed),
    .cfg_we        (cfg_we),
    .cfg_word      (cfg_word)
);

// File: tb/tb_ata_timing_cfg.sv
module tb_ata_timing_cfg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_fast = 1'b0;
    logic [1:0]  drv_present = '0, drv_dma_en = '0, drv_udma_en = '0;
    logic [5:0]  pio_mode = '0, dma_mode = '0, udma_mode = '0;
    logic        sel_valid = 1'b0, sel_drive = 1'b0;
    logic        busy, done, mode_err, rewrite_armed, cfg_we;
    logic [31:0] cfg_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ata_timing_cfg dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_fast(fmt_fast),
        .drv_present(drv_present), .drv_dma_en(drv_dma_en),
        .drv_udma_en(drv_udma_en), .pio_mode(pio_mode), .dma_mode(dma_mode),
        .udma_mode(udma_mode), .sel_valid(sel_valid), .sel_drive(sel_drive),
        .busy(busy), .done(done), .mode_err(mode_err),
        .rewrite_armed(rewrite_armed), .cfg_we(cfg_we), .cfg_word(cfg_word)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // runs one computation; checks latency, busy, strobe, word, arm, error
    task automatic run(input string req, input logic fast,
                       input logic [1:0] pr, input logic [1:0] de,
                       input logic [1:0] ue, input logic [5:0] pm,
                       input logic [5:0] dm, input logic [5:0] um,
                       input logic exp_we, input logic [31:0] exp_word,
                       input logic exp_arm, input logic exp_err);
        int lat;
        fmt_fast = fast; drv_present = pr; drv_dma_en = de; drv_udma_en = ue;
        pio_mode = pm; dma_mode = dm; udma_mode = um;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R11 busy"}, 32'(busy), 32'd1);
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check({req, " R8 latency"}, 32'(lat), 32'd4);
        check({req, " R8 we"}, 32'(cfg_we), 32'(exp_we));
        if (exp_we) check({req, " word"}, cfg_word, exp_word);
        check({req, " R9 armed"}, 32'(rewrite_armed), 32'(exp_arm));
        check({req, " R7 err"}, 32'(mode_err), 32'(exp_err));
        @(negedge clk);
    endtask

    task automatic sel(input string req, input logic d, input logic exp_we,
                       input logic [31:0] exp_word);
        sel_valid = 1'b1; sel_drive = d;
        @(negedge clk);
        sel_valid = 1'b0;
        check({req, " R10 we"}, 32'(cfg_we), 32'(exp_we));
        if (exp_we) check({req, " R10 word"}, cfg_word, exp_word);
        @(negedge clk);
        check({req, " R10 single"}, 32'(cfg_we), 32'd0);
    endtask

    task automatic t_reset();
        check("reset we", 32'(cfg_we), 0);
        check("reset busy R11", 32'(busy), 0);
        check("reset armed R9", 32'(rewrite_armed), 0);
        check("reset word", cfg_word, 0);
    endtask

    task automatic t_legacy_pio();   // R1
        run("R1 legacy pio", 0, 2'b11, 2'b00, 2'b00, {3'd4, 3'd0}, 0, 0,
            1, 32'h146, 1, 0);
        sel("R1 d1", 1, 1, 32'h23);
        sel("R1 d0", 0, 1, 32'h146);
    endtask

    task automatic t_legacy_dma();   // R2, R6
        run("R2 d0 dma0", 0, 2'b01, 2'b01, 2'b00, {3'd0, 3'd1}, {3'd0, 3'd0}, 0,
            1, 32'h74085, 0, 0);
        sel("R10 unarmed", 1, 0, 0);
        run("R2 R6 d1 only", 0, 2'b10, 2'b10, 2'b00, {3'd2, 3'd0}, {3'd2, 3'd0}, 0,
            1, 32'h11824, 0, 0);
        run("R2 d0 dma1", 0, 2'b01, 2'b01, 2'b00, {3'd0, 3'd3}, {3'd0, 3'd1}, 0,
            1, 32'h21823, 0, 0);
    endtask

    task automatic t_fast();         // R3, R4, R5
        run("R3 R4 R5 fast", 1, 2'b11, 2'b11, 2'b11, {3'd4, 3'd0},
            {3'd2, 3'd0}, {3'd4, 3'd0}, 1, 32'h1918438C, 1, 0);
        sel("R5 d1", 1, 1, 32'h0C519465);
        run("R4 fast dma1", 1, 2'b01, 2'b01, 2'b00, {3'd0, 3'd4}, {3'd0, 3'd1}, 0,
            1, 32'h29865, 0, 0);
        run("R5 udma2", 1, 2'b00, 2'b00, 2'b01, 0, 0, {3'd0, 3'd2},
            1, 32'h10900000, 0, 0);
    endtask

    task automatic t_legacy_udma_ignored();  // R5
        run("R5 legacy udma ignored", 0, 2'b01, 2'b00, 2'b01, {3'd0, 3'd3}, 0,
            {3'd0, 3'd7}, 1, 32'h23, 0, 0);
    endtask

    task automatic t_equal();        // R9
        run("R9 equal", 0, 2'b11, 2'b00, 2'b00, {3'd0, 3'd0}, 0, 0,
            1, 32'h146, 0, 0);
        sel("R9 equal sel", 0, 0, 0);
    endtask

    task automatic t_errors();       // R7, R6
        run("R7 bad pio", 0, 2'b11, 2'b00, 2'b00, {3'd0, 3'd5}, 0, 0,
            1, 32'h146, 0, 1);
        run("R7 cleared", 0, 2'b01, 2'b00, 2'b00, {3'd0, 3'd0}, {3'd0, 3'd3}, 0,
            1, 32'h146, 0, 0);
        run("R7 bad dma", 1, 2'b00, 2'b10, 2'b00, 0, {3'd3, 3'd0}, 0,
            0, 0, 0, 1);
        run("R6 none", 0, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_legacy_pio();
        t_legacy_dma();
        t_fast();
        t_legacy_udma_ignored();
        t_equal();
        t_errors();
        finished = 1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule